// File: doc/BRIEF.md
# Marker-Based Byte Aligner

This block recovers the byte framing of an 8-bit parallel word stream whose bit phase is correct but whose word boundary is arbitrary. This is the usual state of a receive lane after bit-level clock/data calibration. The block keeps the previous word next to the current one. It tests every bit offset of that two-word window against a fixed marker byte (0xA1) and remembers which offset produced the match. From then on, a one-hot barrel multiplexer rebuilds bytes on that boundary.

The controller starts in an idle state and waits for a one-cycle request. It then hunts for the marker and locks once the marker is found. A new request can be issued at any time. It drops the lock and starts a fresh hunt. Reset returns the block to idle.

Top module: `mark_byte_aligner`

## Requirements
- R1: While rst_ni is low, and after reset until the first lock, done_o and valid_o are 0, data_o is 8'h00 and shift_o is 0.
- R2: The window is the 16-bit value W = {word sampled at the latest edge, word sampled one edge earlier}. Offset k (0..7) matches when W[15-k:8-k] equals 8'hA1.
- R3: If several offsets match in the same window, the lowest offset is selected.
- R4: The marker counts only if its word completing the window is sampled at the align edge or later. If that word is sampled at edge n, done_o and valid_o are still 0 after edge n and are 1 after edge n+1, with shift_o equal to the matched offset. A stream misaligned by seven bits locks with shift_o = 7.
- R5: While locked with offset k, after each edge data_o equals W[15-k:8-k] of the current window. The first valid byte is therefore the byte that follows the marker.
- R6: While locked and with no align pulse, done_o stays 1 and shift_o stays fixed, even when further marker patterns arrive at other offsets.
- R7: An align pulse sampled at an edge forces done_o and valid_o to 0 after that edge and starts a new hunt. The next marker sets a new offset.
- R8: Markers that arrive while the block is idle (no align since reset) are ignored: done_o stays 0.
- R9: When valid_o is 0, data_o is 8'h00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Word clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| align_i | input | 1 | One-cycle request to start a marker hunt |
| data_i | input | 8 | Deserialized word with unknown framing |
| data_o | output | 8 | Realigned byte |
| valid_o | output | 1 | data_o carries a realigned byte |
| done_o | output | 1 | Marker found and shifter locked |
| shift_o | output | 3 | Locked bit offset |

## Verification
The hardest situation to reach is a window where two offsets match at once, because the marker overlaps itself only at a shift of seven bits. The bench builds that window directly: it sends the word 0x42 followed by 0xA1, which places the marker at offsets 0 and 7 together. It then checks that offset 0 wins. The other locks use word streams that the bench derives from a byte sequence shifted by each of the eight offsets. Zero fill around the marker keeps any lower offset from matching early.

// File: rtl/byte_align_pkg.sv
package byte_align_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SEARCH = 2'd1,
    ST_LOCKED = 2'd2
  } align_state_e;
endpackage

// File: rtl/ba_marker_detect.sv
module ba_marker_detect #(
  parameter int W = 8,
  parameter logic [W-1:0] MARKER = 8'hA1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [W-1:0]   cur_i,
  input  logic [W-1:0]   prev_i,
  output logic [W-1:0]   hit_o
);
  localparam int WW = 2 * W;

  logic [WW-1:0] win;
  logic [W-1:0]  hit_d;

  assign win = {cur_i, prev_i};

  // one comparator per bit offset
  for (genvar k = 0; k < W; k++) begin : g_cmp
    assign hit_d[k] = (win[WW-1-k -: W] == MARKER);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hit_o <= '0;
    else         hit_o <= hit_d;
  end
endmodule

// File: rtl/ba_ctrl.sv
module ba_ctrl
  import byte_align_pkg::*;
#(
  parameter int W   = 8,
  parameter int SHW = $clog2(W)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           align_i,
  input  logic [W-1:0]   hit_i,
  output logic [W-1:0]   sel_o,
  output logic [SHW-1:0] shift_o,
  output logic           done_o
);
  align_state_e state_q, state_d;
  logic [W-1:0] sel_q;
  logic         load;

  function automatic logic [W-1:0] lowest_hot(input logic [W-1:0] v);
    logic [W-1:0] r;
    r = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (v[i]) begin
        r    = '0;
        r[i] = 1'b1;
      end
    end
    return r;
  endfunction

  function automatic logic [SHW-1:0] hot_to_idx(input logic [W-1:0] v);
    logic [SHW-1:0] r;
    r = '0;
    for (int i = 0; i < W; i++) begin
      if (v[i]) r = r | SHW'(i);
    end
    return r;
  endfunction

  always_comb begin
    state_d = state_q;
    load    = 1'b0;
    if (align_i) begin
      state_d = ST_SEARCH;
    end else if (state_q == ST_SEARCH && (|hit_i)) begin
      state_d = ST_LOCKED;
      load    = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sel_q   <= '0;
    end else begin
      state_q <= state_d;
      if (load) sel_q <= lowest_hot(hit_i);
    end
  end

  assign sel_o   = sel_q;
  assign shift_o = hot_to_idx(sel_q);
  assign done_o  = (state_q == ST_LOCKED);
endmodule

// File: rtl/ba_barrel.sv
module ba_barrel #(
  parameter int W = 8
) (
  input  logic [2*W-1:0] win_i,
  input  logic [W-1:0]   sel_i,
  input  logic           en_i,
  output logic [W-1:0]   data_o
);
  localparam int WW = 2 * W;

  logic [W-1:0] lane [W];
  logic [W-1:0] acc;

  for (genvar k = 0; k < W; k++) begin : g_lane
    assign lane[k] = sel_i[k] ? win_i[WW-1-k -: W] : '0;
  end

  always_comb begin
    acc = '0;
    for (int k = 0; k < W; k++) acc = acc | lane[k];
  end

  assign data_o = en_i ? acc : '0;
endmodule

// File: rtl/mark_byte_aligner.sv
module mark_byte_aligner #(
  parameter int W = 8,
  parameter logic [W-1:0] MARKER = 8'hA1,
  parameter int SHW = $clog2(W)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           align_i,
  input  logic [W-1:0]   data_i,
  output logic [W-1:0]   data_o,
  output logic           valid_o,
  output logic           done_o,
  output logic [SHW-1:0] shift_o
);
  logic [W-1:0]   prev_q;
  logic [2*W-1:0] win_q;
  logic [W-1:0]   hit_q;
  logic [W-1:0]   sel_q;
  logic           done;

  // previous word and the window aligned with the hit register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      win_q  <= '0;
    end else begin
      prev_q <= data_i;
      win_q  <= {data_i, prev_q};
    end
  end

  ba_marker_detect #(.W(W), .MARKER(MARKER)) u_det (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cur_i  (data_i),
    .prev_i (prev_q),
    .hit_o  (hit_q)
  );

  ba_ctrl #(.W(W), .SHW(SHW)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .align_i (align_i),
    .hit_i   (hit_q),
    .sel_o   (sel_q),
    .shift_o (shift_o),
    .done_o  (done)
  );

  ba_barrel #(.W(W)) u_bar (
    .win_i  (win_q),
    .sel_i  (sel_q),
    .en_i   (done),
    .data_o (data_o)
  );

  assign done_o  = done;
  assign valid_o = done;
endmodule

// File: rtl/mark_byte_aligner_chk.sv
module mark_byte_aligner_chk #(
  parameter int W   = 8,
  parameter int SHW = $clog2(W)
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           align_i,
  input logic           done_o,
  input logic [SHW-1:0] shift_o,
  input logic [W-1:0]   hit_i,
  input logic [W-1:0]   sel_i
);
  a_r7_align_clears_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    align_i |=> !done_o);

  a_r6_lock_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !align_i) |=> (done_o && $stable(shift_o)));

  a_r4_lock_needs_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(|hit_i));

  a_r3_single_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_i));
endmodule

bind mark_byte_aligner mark_byte_aligner_chk #(.W(W), .SHW(SHW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .align_i (align_i),
  .done_o  (done_o),
  .shift_o (shift_o),
  .hit_i   (hit_q),
  .sel_i   (sel_q)
);

// File: tb/mark_byte_aligner_tb.sv
module mark_byte_aligner_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       align_i = 1'b0;
  logic [7:0] data_i = '0;
  logic [7:0] data_o;
  logic       valid_o, done_o;
  logic [2:0] shift_o;

  int n_tests = 0;
  int n_fail  = 0;
  logic [7:0] last_w = '0, prev_w = '0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  mark_byte_aligner u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .align_i(align_i), .data_i(data_i),
    .data_o(data_o), .valid_o(valid_o), .done_o(done_o), .shift_o(shift_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // word w_{j+1} carrying byte boundary at offset k
  function automatic logic [7:0] mkw(input logic [7:0] cur, input logic [7:0] nxt, input int k);
    logic [15:0] t;
    t = {nxt, cur} >> k;
    return t[7:0];
  endfunction

  function automatic logic [7:0] slice(input logic [7:0] cur, input logic [7:0] prv, input int k);
    logic [15:0] t;
    t = {cur, prv} >> (8 - k);
    return t[7:0];
  endfunction

  task automatic push(input logic [7:0] w, input logic a);
    @(negedge clk_i);
    data_i  = w;
    align_i = a;
    @(posedge clk_i);
    #1;
    prev_w = last_w;
    last_w = w;
    align_i = 1'b0;
  endtask

  task automatic flush();
    push(8'h00, 1'b0);
    push(8'h00, 1'b0);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    #(CLK_PERIOD * 2);
    check("R1 done in reset", done_o, 0);
    check("R1 valid in reset", valid_o, 0);
    check("R1 data in reset", data_o, 8'h00);
    check("R1 shift in reset", shift_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    last_w = '0;
    prev_w = '0;
  endtask

  task automatic t_idle_ignores();
    flush();
    push(8'hA1, 1'b0);
    push(8'h00, 1'b0);
    push(mkw(8'h00, 8'hA1, 5), 1'b0);
    push(mkw(8'hA1, 8'h00, 5), 1'b0);
    push(8'h00, 1'b0);
    check("R8 idle done", done_o, 0);
    check("R8 idle valid", valid_o, 0);
    check("R9 idle data zero", data_o, 8'h00);
  endtask

  task automatic t_lock(input int k, input logic [7:0] p0, input logic [7:0] p1);
    flush();
    push(mkw(8'h00, 8'hA1, k), 1'b1);
    check("R7 done cleared by align", done_o, 0);
    push(mkw(8'hA1, 8'h00, k), 1'b0);
    check("R4 no lock on marker edge", done_o, 0);
    check("R9 data zero while hunting", data_o, 8'h00);
    push(mkw(8'h00, p0, k), 1'b0);
    check("R4 done after lock", done_o, 1);
    check("R4 valid after lock", valid_o, 1);
    check("R2 R4 shift offset", shift_o, k);
    check("R5 first byte after marker", data_o, 8'h00);
    push(mkw(p0, p1, k), 1'b0);
    check("R5 payload byte 0", data_o, p0);
    push(mkw(p1, 8'h00, k), 1'b0);
    check("R5 payload byte 1", data_o, p1);
  endtask

  task automatic t_hold(input int k);
    logic [7:0] seq [6];
    seq[0] = 8'hA1; seq[1] = 8'h00; seq[2] = 8'h50; seq[3] = 8'h80;
    seq[4] = 8'h3C; seq[5] = 8'hA1;
    for (int i = 0; i < 6; i++) begin
      push(seq[i], 1'b0);
      check("R6 stays locked", done_o, 1);
      check("R6 shift held", shift_o, k);
      check("R5 R6 data follows lock", data_o, slice(last_w, prev_w, k));
    end
  endtask

  task automatic t_overlap();
    flush();
    push(8'h00, 1'b1);
    push(8'h42, 1'b0);
    push(8'hA1, 1'b0);
    check("R3 not yet locked", done_o, 0);
    push(8'h5A, 1'b0);
    check("R3 locked on overlap", done_o, 1);
    check("R3 lowest offset wins", shift_o, 0);
    check("R3 data at offset 0", data_o, 8'h5A);
  endtask

  task automatic t_reset_locked();
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check("R1 reset clears done", done_o, 0);
    check("R1 reset clears shift", shift_o, 0);
    check("R1 reset clears data", data_o, 8'h00);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_idle_ignores();
    for (int k = 0; k < 8; k++) t_lock(k, 8'h3C + 8'(k), 8'hC5 ^ 8'(k));
    t_hold(7);
    t_lock(3, 8'h96, 8'h69);
    t_hold(3);
    t_overlap();
    t_reset_locked();
    t_idle_ignores();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule